// File: doc/BRIEF.md
# I2C Multi-Function Slave Address Front End

This block sits behind the SCL and SDA pins of a serial device that hosts three internal functions: a memory array, a bank of clock registers and a bank of control registers. It watches the bus in the system clock domain and finds START, repeated START and STOP conditions. It shifts in the first byte after every start and decodes that byte. When the byte names one of the three functions and carries this device's select ID, the block pulls SDA low for the acknowledge clock. It then tells the logic behind it which function was chosen, the transfer direction and, for memory, the top memory address bit.

The block also follows the high-speed entry sequence. A master code byte sent right after a START in fast/standard mode is left unacknowledged, and the block then enters high-speed mode. It stays in that mode across repeated STARTs and transfers until a STOP ends it. An `hs_mode` output lets a later timing or filter stage widen or narrow its settings. Data bytes after the acknowledge are handled elsewhere.

The controller runs five states. `ST_IDLE` waits for a START. `ST_ADDR` shifts eight bits. `ST_ACK` drives the acknowledge. `ST_MCODE` lets a master code pass unacknowledged. `ST_HOLD` ignores the bus until the next start. The transitions are:
- START goes from any state to `ST_ADDR`.
- STOP goes from any state to `ST_IDLE`.
- The eighth falling SCL goes from `ST_ADDR` to `ST_ACK` on a match, to `ST_MCODE` on a master code, and to `ST_HOLD` otherwise.
- The ninth falling SCL goes from `ST_ACK` or `ST_MCODE` to `ST_HOLD`.

Top module: `i2cf_slave_front`

## Requirements
- R1: After reset `sda_oe`, `sel_valid` and `hs_mode` are 0.
- R2: A START (SDA falling while SCL is high) or a repeated START restarts address reception. The next eight bits are sampled on SCL rising edges, MSB first. Bit 0 of the byte appears on `sel_rw` (1 = read).
- R3: A byte with upper nibble 1010 and a matching select ID selects memory. `sel_func` = 2'b01 and `sel_a16` = byte bit 1.
- R4: Upper nibble 1101 selects the clock registers (`sel_func` = 2'b10). Upper nibble 0011 selects the control registers (`sel_func` = 2'b11). In both cases `sel_a16` = 0 and bit 1 is ignored.
- R5: Byte bits [3:2] must equal `dev_strap`. A mismatch, or any other upper nibble, gives no acknowledge (SDA stays high in the ninth clock) and no `sel_valid`.
- R6: On a match, `sda_oe` rises after the eighth SCL falling edge and falls after the ninth SCL falling edge. `sel_valid` pulses for exactly one cycle as `sda_oe` rises.
- R7: In fast/standard mode, a byte 0000_1xxx after a START is not acknowledged and gives no `sel_valid`. `hs_mode` becomes 1 after the ninth SCL falling edge.
- R8: Once set, `hs_mode` stays 1 across repeated STARTs and transfers. In high-speed mode, addresses decode exactly as in R3 to R5, and a 0000_1xxx byte is treated as an unknown nibble.
- R9: A STOP (SDA rising while SCL is high) clears `hs_mode` to 0.
- R10: After a byte that is not acknowledged, further SCL clocks are ignored until the next START or repeated START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| dev_strap | input | 2 | Device select ID strap |
| sda_oe | output | 1 | Open-drain pull-down enable for SDA |
| sel_valid | output | 1 | One-cycle strobe: address accepted |
| sel_func | output | 2 | Selected function: 01 memory, 10 clock, 11 control |
| sel_rw | output | 1 | Direction bit of the accepted address |
| sel_a16 | output | 1 | Upper memory address bit (memory only) |
| hs_mode | output | 1 | High-speed mode flag |

## Verification
All 256 address byte values are sent, each framed by START and STOP, with one fixed strap. This run separates the three function nibbles from every other nibble, master codes from ordinary bytes, and the A16 and R/W bits from the don't-care bit. A smaller sweep crosses all four strap values with all four ID values, which separates ID matches from mismatches. Sequences with master codes and repeated STARTs show that high-speed mode survives restarts and ends only at STOP. Bytes clocked after a not-acknowledged address show that the idle hold ignores them until a new start.

// File: rtl/i2cf_pkg.sv
package i2cf_pkg;
    localparam int BYTE_W = 8;
    localparam int ID_W   = 2;

    typedef enum logic [1:0] {
        FN_NONE = 2'b00,
        FN_MEM  = 2'b01,
        FN_CLK  = 2'b10,
        FN_CTL  = 2'b11
    } fn_e;

    localparam logic [3:0] NIB_MEM   = 4'b1010;
    localparam logic [3:0] NIB_CLK   = 4'b1101;
    localparam logic [3:0] NIB_CTL   = 4'b0011;
    localparam logic [4:0] MCODE_PFX = 5'b00001;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_MCODE,
        ST_HOLD
    } st_e;
endpackage

// File: rtl/i2cf_line_cond.sv
module i2cf_line_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_prev;
    logic                   sda_prev;
    logic                   scl_q;

    // Idle bus level is high, so reset to ones to avoid false edges.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe[0] <= scl_in;
            sda_pipe[0] <= sda_in;
            for (int i = 1; i < SYNC_STAGES; i++) begin
                scl_pipe[i] <= scl_pipe[i-1];
                sda_pipe[i] <= sda_pipe[i-1];
            end
            scl_prev <= scl_pipe[LAST];
            sda_prev <= sda_pipe[LAST];
        end
    end

    assign scl_q     = scl_pipe[LAST];
    assign sda_q     = sda_pipe[LAST];
    assign scl_rise  = scl_q & ~scl_prev;
    assign scl_fall  = ~scl_q & scl_prev;
    assign start_det = scl_q & scl_prev & sda_prev & ~sda_q;
    assign stop_det  = scl_q & scl_prev & ~sda_prev & sda_q;
endmodule

// File: rtl/i2cf_addr_decode.sv
module i2cf_addr_decode
    import i2cf_pkg::*;
(
    input  logic [BYTE_W-1:0] addr_byte,
    input  logic [ID_W-1:0]   dev_strap,
    input  logic              hs_mode,
    output logic              dec_match,
    output logic              dec_mcode,
    output fn_e               dec_func,
    output logic              dec_a16
);
    logic [3:0]      nib;
    logic [ID_W-1:0] id_bits;
    logic            id_ok;

    assign nib     = addr_byte[BYTE_W-1 -: 4];
    assign id_bits = addr_byte[3:2];
    assign id_ok   = (id_bits == dev_strap);

    always_comb begin
        dec_func = FN_NONE;
        unique case (nib)
            NIB_MEM: dec_func = FN_MEM;
            NIB_CLK: dec_func = FN_CLK;
            NIB_CTL: dec_func = FN_CTL;
            default: dec_func = FN_NONE;
        endcase
    end

    assign dec_match = id_ok && (dec_func != FN_NONE);
    assign dec_a16   = (dec_func == FN_MEM) ? addr_byte[1] : 1'b0;
    assign dec_mcode = !hs_mode && (addr_byte[BYTE_W-1 -: 5] == MCODE_PFX);
endmodule

// File: rtl/i2cf_ctrl_fsm.sv
module i2cf_ctrl_fsm
    import i2cf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_q,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              dec_match,
    input  logic              dec_mcode,
    input  fn_e               dec_func,
    input  logic              dec_a16,
    output logic [BYTE_W-1:0] shreg,
    output logic              sda_oe,
    output logic              sel_valid,
    output fn_e               sel_func,
    output logic              sel_rw,
    output logic              sel_a16,
    output logic              hs_mode
);
    localparam int CNT_W = $clog2(BYTE_W + 1);

    st_e             state;
    st_e             next;
    logic [CNT_W-1:0] bit_cnt;
    logic             ack_clk;
    logic             byte_done;

    assign byte_done = scl_fall && (bit_cnt == CNT_W'(BYTE_W));

    // Next-state logic
    always_comb begin
        next = state;
        if (stop_det) begin
            next = ST_IDLE;
        end else if (start_det) begin
            next = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:  next = ST_IDLE;
                ST_ADDR: begin
                    if (byte_done) begin
                        if (dec_match)      next = ST_ACK;
                        else if (dec_mcode) next = ST_MCODE;
                        else                next = ST_HOLD;
                    end
                end
                ST_ACK:   if (scl_fall && ack_clk) next = ST_HOLD;
                ST_MCODE: if (scl_fall && ack_clk) next = ST_HOLD;
                ST_HOLD:  next = ST_HOLD;
                default:  next = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= next;
    end

    // Shift register, bit counter and ninth-clock tracker
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
            ack_clk <= 1'b0;
        end else begin
            if (start_det) begin
                bit_cnt <= '0;
                ack_clk <= 1'b0;
            end else if (state == ST_ADDR) begin
                ack_clk <= 1'b0;
                if (scl_rise && bit_cnt < CNT_W'(BYTE_W)) begin
                    shreg   <= {shreg[BYTE_W-2:0], sda_q};
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end else if (state == ST_ACK || state == ST_MCODE) begin
                if (scl_rise) ack_clk <= 1'b1;
            end
        end
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe    <= 1'b0;
            sel_valid <= 1'b0;
            sel_func  <= FN_NONE;
            sel_rw    <= 1'b0;
            sel_a16   <= 1'b0;
            hs_mode   <= 1'b0;
        end else begin
            sel_valid <= 1'b0;
            if (stop_det) begin
                sda_oe  <= 1'b0;
                hs_mode <= 1'b0;
            end else if (start_det) begin
                sda_oe <= 1'b0;
            end else begin
                if (state == ST_ADDR && next == ST_ACK) begin
                    sda_oe    <= 1'b1;
                    sel_valid <= 1'b1;
                    sel_func  <= dec_func;
                    sel_rw    <= shreg[0];
                    sel_a16   <= dec_a16;
                end
                if (state == ST_ACK && next == ST_HOLD) begin
                    sda_oe <= 1'b0;
                end
                if (state == ST_MCODE && next == ST_HOLD) begin
                    hs_mode <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/i2cf_slave_front.sv
module i2cf_slave_front
    import i2cf_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic [1:0] dev_strap,
    output logic       sda_oe,
    output logic       sel_valid,
    output logic [1:0] sel_func,
    output logic       sel_rw,
    output logic       sel_a16,
    output logic       hs_mode
);
    logic              sda_q;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic [BYTE_W-1:0] shreg;
    logic              dec_match;
    logic              dec_mcode;
    fn_e               dec_func;
    logic              dec_a16;
    fn_e               func_q;

    i2cf_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_q     (sda_q),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2cf_addr_decode u_dec (
        .addr_byte (shreg),
        .dev_strap (dev_strap),
        .hs_mode   (hs_mode),
        .dec_match (dec_match),
        .dec_mcode (dec_mcode),
        .dec_func  (dec_func),
        .dec_a16   (dec_a16)
    );

    i2cf_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_q     (sda_q),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .dec_match (dec_match),
        .dec_mcode (dec_mcode),
        .dec_func  (dec_func),
        .dec_a16   (dec_a16),
        .shreg     (shreg),
        .sda_oe    (sda_oe),
        .sel_valid (sel_valid),
        .sel_func  (func_q),
        .sel_rw    (sel_rw),
        .sel_a16   (sel_a16),
        .hs_mode   (hs_mode)
    );

    assign sel_func = func_q;
endmodule

// File: rtl/i2cf_chk.sv
module i2cf_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_det,
    input logic       stop_det,
    input logic       sda_oe,
    input logic       sel_valid,
    input logic [1:0] sel_func,
    input logic       sel_a16,
    input logic       hs_mode
);
    // R9: a STOP leaves high-speed mode
    a_r9_stop_clears_hs: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !hs_mode);

    // R6: the accept strobe lasts one cycle
    a_r6_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |=> !sel_valid);

    // R6: the acknowledge drive begins together with the strobe
    a_r6_oe_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> sel_valid);

    // R5: an accepted address always names a function
    a_r5_valid_has_func: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> sel_func != 2'b00);

    // R4: only the memory function carries the upper address bit
    a_r4_a16_mem_only: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && sel_func != 2'b01) |-> !sel_a16);

    // R7: high-speed entry never comes with an acknowledge
    a_r7_hs_entry_nak: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_mode) |-> !sda_oe);

    // R2: a new start releases the data line
    a_r2_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe);
endmodule

bind i2cf_slave_front i2cf_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe),
    .sel_valid (sel_valid),
    .sel_func  (sel_func),
    .sel_a16   (sel_a16),
    .hs_mode   (hs_mode)
);

// File: tb/test_i2cf_slave_front.sv
module test_i2cf_slave_front;
    localparam int Q = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [1:0] strap = 2'b10;
    logic       sda_oe, sel_valid, sel_rw, sel_a16, hs_mode;
    logic [1:0] sel_func;
    logic       sda_bus;
    int         checks = 0;
    int         errors = 0;
    int         vtotal = 0;
    logic [1:0] cap_func;
    logic       cap_rw, cap_a16;

    always #2.5 clk = ~clk;

    assign sda_bus = m_sda & ~sda_oe;

    i2cf_slave_front i_i2cf_slave_front (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (m_scl),
        .sda_in    (sda_bus),
        .dev_strap (strap),
        .sda_oe    (sda_oe),
        .sel_valid (sel_valid),
        .sel_func  (sel_func),
        .sel_rw    (sel_rw),
        .sel_a16   (sel_a16),
        .hs_mode   (hs_mode)
    );

    always @(posedge clk) begin
        if (sel_valid) begin
            vtotal   <= vtotal + 1;
            cap_func <= sel_func;
            cap_rw   <= sel_rw;
            cap_a16  <= sel_a16;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b1; wq(); wq();
    endtask

    // Eight bits MSB first plus the ninth clock; returns SDA seen mid ninth high.
    task automatic send_byte(input logic [7:0] b, output logic ninth);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wq();
            m_scl = 1'b1; wq(); wq();
            m_scl = 1'b0; wq();
        end
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        ninth = sda_bus;
        wq();
        m_scl = 1'b0; wq();
    endtask

    function automatic int exp_func(input logic [7:0] b);
        case (b[7:4])
            4'b1010: return 1;
            4'b1101: return 2;
            4'b0011: return 3;
            default: return 0;
        endcase
    endfunction

    // One framed address with all checks; mode is the hs state before it.
    task automatic one_addr(input logic [7:0] b, input logic in_hs);
        logic ninth;
        int   base, f, m, mc;
        f    = exp_func(b);
        m    = (f != 0 && b[3:2] == strap) ? 1 : 0;
        mc   = (!in_hs && b[7:3] == 5'b00001) ? 1 : 0;
        base = vtotal;
        send_byte(b, ninth);
        chk(m ? "R6 ack" : "R5 nak", ninth, m ? 0 : 1);
        chk("R6 valid count", vtotal - base, m);
        chk("R6 oe released", sda_oe, 0);
        if (m != 0) begin
            chk("R3/R4 func", cap_func, f);
            chk("R2 rw", cap_rw, b[0]);
            chk(f == 1 ? "R3 a16" : "R4 a16", cap_a16, f == 1 ? b[1] : 0);
        end
        chk(mc ? "R7 hs set" : "R8 hs kept", hs_mode, (in_hs || mc) ? 1 : 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual 1 expected 0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic ninth;
        int   base;
        repeat (4) @(negedge clk);
        chk("R1 oe", sda_oe, 0);
        chk("R1 valid", sel_valid, 0);
        chk("R1 hs", hs_mode, 0);
        rst_n = 1'b1;
        wq();
        chk("R1 hs after release", hs_mode, 0);

        // Full byte sweep, each framed by START and STOP
        for (int b = 0; b < 256; b++) begin
            bus_start();
            one_addr(8'(b), 1'b0);
            bus_stop();
            chk("R9 stop clears", hs_mode, 0);
        end

        // Strap against ID cross sweep (memory and control nibbles)
        for (int s = 0; s < 4; s++) begin
            strap = 2'(s);
            for (int id = 0; id < 4; id++) begin
                bus_start();
                one_addr({4'b1010, 2'(id), 2'b11}, 1'b0);
                bus_stop();
                bus_start();
                one_addr({4'b0011, 2'(id), 2'b10}, 1'b0);
                bus_stop();
            end
        end
        strap = 2'b01;

        // R8: high-speed mode across repeated STARTs
        bus_start();
        one_addr(8'h0D, 1'b0);
        bus_start();
        one_addr(8'hA7, 1'b1);
        bus_start();
        one_addr(8'hD4, 1'b1);
        bus_start();
        one_addr(8'h0B, 1'b1);
        bus_start();
        one_addr(8'h35, 1'b1);
        bus_start();
        one_addr(8'hA0, 1'b1);
        chk("R8 hs before stop", hs_mode, 1);
        bus_stop();
        chk("R9 hs after stop", hs_mode, 0);

        // R10: after a NAK, further bytes are ignored until a new start
        bus_start();
        one_addr(8'hA8, 1'b0);
        base = vtotal;
        send_byte(8'hA4, ninth);
        chk("R10 ignored ack", ninth, 1);
        chk("R10 ignored valid", vtotal - base, 0);
        send_byte(8'h35, ninth);
        chk("R10 ignored ack2", ninth, 1);
        bus_start();
        one_addr(8'hA5, 1'b0);
        bus_stop();

        // R10: same after a master code; a plain byte must not be acked
        bus_start();
        one_addr(8'h08, 1'b0);
        base = vtotal;
        send_byte(8'hA4, ninth);
        chk("R10 after mcode ack", ninth, 1);
        chk("R10 after mcode valid", vtotal - base, 0);
        chk("R8 hs held", hs_mode, 1);
        bus_stop();
        chk("R9 final", hs_mode, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule